// File: doc/BRIEF.md
# Mixed-Criticality Ready-Task Selector

This block picks, every clock cycle, which task a real-time coprocessor should run next. It keeps a small table of task entries. Each entry carries a criticality class (non-real-time, soft real-time or hard real-time), a period, an arrival stamp and an absolute deadline. A free-running 16-bit time base drives the deadline arithmetic. A single command port creates, activates, puts to sleep and terminates tasks. The block drives out the identifier of the task to dispatch, a valid bit, and a one-cycle preempt pulse when a still-ready task is displaced.

Each class is ordered by its own policy. Hard tasks are ordered by nearest absolute deadline. Soft tasks are ordered by shortest period. Non-real-time tasks are ordered by arrival. A ready task of a higher class always beats every task of a lower class. There is no blocked state. A task that has to wait is put to sleep with a delay, and a per-entry timer makes it ready again when the delay runs out. Nested preemptions unwind in last-in first-out order, because each task that preempts outranks the one it displaced.

Top module: `mixcrit_sched`

## Requirements
- R1: After reset, `dispatch_valid` and `preempt` are 0. `dispatch_valid` is 1 in the cycle after at least one task is ready, and 0 in the cycle after no task is ready.
- R2: The class is taken from `cmd_class` at create: 0 is non-real-time, 1 is soft, and 2 or 3 is hard. A ready task of a higher class is dispatched ahead of every ready task of a lower class.
- R3: Among ready non-real-time tasks, the one that became ready earliest is dispatched.
- R4: Among ready soft tasks, the one with the shortest period is dispatched, whatever the order of activation.
- R5: Among ready hard tasks, the one with the nearest absolute deadline is dispatched. The deadline is the activation time plus the period.
- R6: The time base advances by one each cycle and wraps modulo 2^16. Deadlines are compared by their distance ahead of the current time, so a deadline that has wrapped past zero still counts as later.
- R7: Ties within a class go to the lower task identifier.
- R8: `cmd_op` encoding: 0 creates an idle entry (class, and period = `cmd_value`); 1 activates; 2 sleeps; 3 terminates. The effect of a command appears on the dispatch outputs on the second clock edge after it is presented, and not before.
- R9: Sleep makes the task not ready. The task becomes ready again by itself `cmd_value` cycles after the sleep, with a fresh arrival stamp and a fresh deadline.
- R10: `preempt` pulses for one cycle when the dispatched identifier changes while the previously dispatched task is still ready. It stays 0 when the previous task terminated or went to sleep.
- R11: Activating an absent entry has no effect. Activating an already-ready entry has no effect and keeps its original arrival stamp.
- R12: With nested preemption, terminating the preempting tasks resumes the displaced tasks in last-in first-out order.
- R13: A timer wake-up and a command to another entry in the same cycle both take effect. Both arrivals get the same stamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command code (see R8) |
| cmd_id | input | 3 | Target task identifier |
| cmd_class | input | 2 | Class, used by create |
| cmd_value | input | 16 | Period for create, delay for sleep |
| dispatch_valid | output | 1 | A task is selected |
| dispatch_id | output | 3 | Selected task identifier |
| preempt | output | 1 | One-cycle pulse on displacement of a ready task |

## Verification
A timer wake-up of one entry and an explicit activation of another can land on the same clock edge. Both feed the shared arrival stamp and the selection in that edge. The bench puts one non-real-time task to sleep and counts cycles, so that the activation of a second non-real-time task is applied on exactly the wake-up edge. It then expects the lower identifier to win on the tied stamp. After terminating that task, it expects the other task to be dispatched, which shows that neither arrival was lost.

// File: rtl/mixcrit_pkg.sv
package mixcrit_pkg;

   typedef enum logic [1:0] {
      OP_CREATE   = 2'd0,
      OP_ACTIVATE = 2'd1,
      OP_SLEEP    = 2'd2,
      OP_KILL     = 2'd3
   } op_e;

   localparam logic [1:0] RANK_NRT  = 2'd0;
   localparam logic [1:0] RANK_SOFT = 2'd1;
   localparam logic [1:0] RANK_HARD = 2'd2;

   // Codes 2 and 3 both map to the hard class.
   function automatic logic [1:0] rank_of(input logic [1:0] cls);
      return (cls[1]) ? RANK_HARD : cls;
   endfunction

endpackage

// File: rtl/mixcrit_entry.sv
module mixcrit_entry
   import mixcrit_pkg::*;
#(
   parameter int TIME_W = 16,
   parameter int SEQ_W  = 8,
   parameter int KEY_W  = TIME_W + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_hit,
   input  op_e               cmd_op,
   input  logic [1:0]        cmd_class,
   input  logic [TIME_W-1:0] cmd_value,
   input  logic [TIME_W-1:0] now,
   input  logic [SEQ_W-1:0]  stamp,
   output logic              ready,
   output logic              arrive,
   output logic [1:0]        rank,
   output logic [KEY_W-1:0]  key
);

   logic              present_q, sleeping_q;
   logic [1:0]        rank_q;
   logic [TIME_W-1:0] period_q, deadline_q, wake_q;
   logic [SEQ_W-1:0]  seq_q;
   logic [TIME_W-1:0] metric;
   logic              wake_hit;

   assign wake_hit = sleeping_q && (now == wake_q);
   assign arrive   = (cmd_hit && cmd_op == OP_ACTIVATE && present_q && !ready)
                   || (!cmd_hit && wake_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         present_q  <= 1'b0;
         ready      <= 1'b0;
         sleeping_q <= 1'b0;
         rank_q     <= RANK_NRT;
         period_q   <= '0;
         deadline_q <= '0;
         wake_q     <= '0;
         seq_q      <= '0;
      end else if (arrive) begin
         ready      <= 1'b1;
         sleeping_q <= 1'b0;
         seq_q      <= stamp;
         deadline_q <= now + period_q;
      end else if (cmd_hit) begin
         case (cmd_op)
            OP_CREATE: begin
               present_q  <= 1'b1;
               ready      <= 1'b0;
               sleeping_q <= 1'b0;
               rank_q     <= rank_of(cmd_class);
               period_q   <= cmd_value;
            end
            OP_SLEEP: begin
               if (present_q) begin
                  ready      <= 1'b0;
                  sleeping_q <= 1'b1;
                  wake_q     <= now + cmd_value;
               end
            end
            OP_KILL: begin
               present_q  <= 1'b0;
               ready      <= 1'b0;
               sleeping_q <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   // Larger metric = more urgent within the class.
   always_comb begin
      case (rank_q)
         RANK_HARD: metric = ~(deadline_q - now);
         RANK_SOFT: metric = ~period_q;
         default:   metric = TIME_W'(stamp - seq_q);
      endcase
   end

   assign rank = rank_q;
   assign key  = {rank_q, metric};

endmodule

// File: rtl/mixcrit_pick.sv
module mixcrit_pick #(
   parameter int N     = 8,
   parameter int KEY_W = 18,
   parameter int ID_W  = 3
) (
   input  logic [N-1:0]       ready,
   input  logic [N*KEY_W-1:0] keys,
   output logic               found,
   output logic [ID_W-1:0]    id
);

   logic [KEY_W-1:0] best;

   // Strict compare keeps the lower index on equal keys.
   always_comb begin
      found = 1'b0;
      id    = '0;
      best  = '0;
      for (int i = 0; i < N; i++) begin
         if (ready[i] && (!found || keys[i*KEY_W +: KEY_W] > best)) begin
            found = 1'b1;
            best  = keys[i*KEY_W +: KEY_W];
            id    = ID_W'(i);
         end
      end
   end

endmodule

// File: rtl/mixcrit_sched.sv
module mixcrit_sched
   import mixcrit_pkg::*;
#(
   parameter int NUM_TASKS = 8,
   parameter int TIME_W    = 16,
   parameter int SEQ_W     = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_valid,
   input  logic [1:0]                   cmd_op,
   input  logic [$clog2(NUM_TASKS)-1:0] cmd_id,
   input  logic [1:0]                   cmd_class,
   input  logic [TIME_W-1:0]            cmd_value,
   output logic                         dispatch_valid,
   output logic [$clog2(NUM_TASKS)-1:0] dispatch_id,
   output logic                         preempt
);

   localparam int ID_W  = $clog2(NUM_TASKS);
   localparam int KEY_W = TIME_W + 2;

   if (NUM_TASKS < 2) begin : g_bad_depth
      $error("mixcrit_sched: NUM_TASKS must be at least 2");
   end
   if (SEQ_W >= TIME_W) begin : g_bad_seq
      $error("mixcrit_sched: SEQ_W must be narrower than TIME_W");
   end

   logic [TIME_W-1:0]      now_q;
   logic [SEQ_W-1:0]       stamp_q;
   logic [NUM_TASKS-1:0]   ready_vec, arrive_vec;
   logic [2*NUM_TASKS-1:0] rank_flat;
   logic [NUM_TASKS*KEY_W-1:0] key_flat;
   logic                   sel_found;
   logic [ID_W-1:0]        sel_id;

   for (genvar g = 0; g < NUM_TASKS; g++) begin : g_entry
      mixcrit_entry #(
         .TIME_W (TIME_W),
         .SEQ_W  (SEQ_W),
         .KEY_W  (KEY_W)
      ) u_entry (
         .clk       (clk),
         .rst_n     (rst_n),
         .cmd_hit   (cmd_valid && (cmd_id == ID_W'(g))),
         .cmd_op    (op_e'(cmd_op)),
         .cmd_class (cmd_class),
         .cmd_value (cmd_value),
         .now       (now_q),
         .stamp     (stamp_q),
         .ready     (ready_vec[g]),
         .arrive    (arrive_vec[g]),
         .rank      (rank_flat[2*g +: 2]),
         .key       (key_flat[g*KEY_W +: KEY_W])
      );
   end

   mixcrit_pick #(
      .N     (NUM_TASKS),
      .KEY_W (KEY_W),
      .ID_W  (ID_W)
   ) u_pick (
      .ready (ready_vec),
      .keys  (key_flat),
      .found (sel_found),
      .id    (sel_id)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         now_q          <= '0;
         stamp_q        <= '0;
         dispatch_valid <= 1'b0;
         dispatch_id    <= '0;
         preempt        <= 1'b0;
      end else begin
         now_q          <= now_q + 1'b1;
         stamp_q        <= stamp_q + SEQ_W'(|arrive_vec);
         dispatch_valid <= sel_found;
         dispatch_id    <= sel_id;
         preempt        <= sel_found && dispatch_valid
                           && (sel_id != dispatch_id)
                           && ready_vec[dispatch_id];
      end
   end

endmodule

// File: rtl/mixcrit_sched_chk.sv
module mixcrit_sched_chk #(
   parameter int N      = 8,
   parameter int ID_W   = 3,
   parameter int TIME_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [N-1:0]       ready_vec,
   input logic [2*N-1:0]     rank_flat,
   input logic [TIME_W-1:0]  now,
   input logic               dispatch_valid,
   input logic [ID_W-1:0]    dispatch_id,
   input logic               preempt
);

   logic [N-1:0]   ready_q;
   logic [2*N-1:0] rank_q;
   logic [1:0]     maxr, maxr_q;
   logic           armed;

   always_comb begin
      maxr = 2'd0;
      for (int i = 0; i < N; i++)
         if (ready_vec[i] && rank_flat[2*i +: 2] > maxr) maxr = rank_flat[2*i +: 2];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= '0;
         rank_q  <= '0;
         maxr_q  <= '0;
         armed   <= 1'b0;
      end else begin
         ready_q <= ready_vec;
         rank_q  <= rank_flat;
         maxr_q  <= maxr;
         armed   <= 1'b1;
      end
   end

   // R1
   any_ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|ready_vec) |=> dispatch_valid);
   // R1
   none_ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|ready_vec) |=> !dispatch_valid);
   // R1
   dispatched_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dispatch_valid |-> ready_q[dispatch_id]);
   // R2
   class_dominance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dispatch_valid |-> (rank_q[2*dispatch_id +: 2] == maxr_q));
   // R6
   time_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (now == $past(now) + 1'b1));
   // R10
   preempt_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      preempt |-> (dispatch_valid && $past(dispatch_valid)
                   && dispatch_id != $past(dispatch_id)));

endmodule

bind mixcrit_sched mixcrit_sched_chk #(
   .N      (NUM_TASKS),
   .ID_W   (ID_W),
   .TIME_W (TIME_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .ready_vec      (ready_vec),
   .rank_flat      (rank_flat),
   .now            (now_q),
   .dispatch_valid (dispatch_valid),
   .dispatch_id    (dispatch_id),
   .preempt        (preempt)
);

// File: tb/mixcrit_sched_bench.sv
module mixcrit_sched_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = '0;
   logic [2:0]  cmd_id = '0;
   logic [1:0]  cmd_class = '0;
   logic [15:0] cmd_value = '0;
   logic        dispatch_valid;
   logic [2:0]  dispatch_id;
   logic        preempt;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   localparam logic [1:0] C_CREATE = 2'd0, C_ACT = 2'd1, C_SLEEP = 2'd2, C_KILL = 2'd3;
   localparam logic [1:0] K_NRT = 2'd0, K_SOFT = 2'd1, K_HARD = 2'd2;

   always #4 clk = ~clk;

   mixcrit_sched u_mixcrit_sched (
      .clk            (clk),
      .rst_n          (rst_n),
      .cmd_valid      (cmd_valid),
      .cmd_op         (cmd_op),
      .cmd_id         (cmd_id),
      .cmd_class      (cmd_class),
      .cmd_value      (cmd_value),
      .dispatch_valid (dispatch_valid),
      .dispatch_id    (dispatch_id),
      .preempt        (preempt)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Presented at a falling edge, applied at the next rising edge.
   task automatic cmd(input logic [1:0] op, input int id, input logic [1:0] cls, input int val);
      cmd_valid = 1'b1;
      cmd_op    = op;
      cmd_id    = 3'(id);
      cmd_class = cls;
      cmd_value = 16'(val);
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   task automatic clear_all();
      for (int i = 0; i < 8; i++) cmd(C_KILL, i, K_NRT, 0);
      settle();
   endtask

   task automatic t_reset();
      chk("R1 reset valid", int'(dispatch_valid), 0);
      chk("R1 reset preempt", int'(preempt), 0);
   endtask

   task automatic t_latency_ignore();
      clear_all();
      cmd(C_ACT, 2, K_NRT, 0);
      settle();
      chk("R11 activate absent", int'(dispatch_valid), 0);
      cmd(C_CREATE, 1, K_NRT, 0);
      cmd(C_CREATE, 2, K_NRT, 0);
      cmd(C_ACT, 1, K_NRT, 0);
      chk("R8 not before second edge", int'(dispatch_valid), 0);
      settle();
      chk("R8 visible after second edge", int'(dispatch_valid), 1);
      cmd(C_ACT, 2, K_NRT, 0);
      cmd(C_ACT, 1, K_NRT, 0);
      settle();
      chk("R11 reactivate keeps stamp", int'(dispatch_id), 1);
   endtask

   task automatic t_fcfs();
      clear_all();
      cmd(C_CREATE, 6, K_NRT, 0);
      cmd(C_CREATE, 1, K_NRT, 0);
      cmd(C_ACT, 6, K_NRT, 0);
      cmd(C_ACT, 1, K_NRT, 0);
      settle();
      chk("R3 earliest arrival", int'(dispatch_id), 6);
      cmd(C_KILL, 6, K_NRT, 0);
      settle();
      chk("R3 next arrival", int'(dispatch_id), 1);
      chk("R10 no preempt on terminate", int'(preempt), 0);
   endtask

   task automatic t_rm_tie();
      clear_all();
      cmd(C_CREATE, 2, K_SOFT, 500);
      cmd(C_CREATE, 5, K_SOFT, 100);
      cmd(C_ACT, 2, K_NRT, 0);
      cmd(C_ACT, 5, K_NRT, 0);
      settle();
      chk("R4 shortest period", int'(dispatch_id), 5);
      clear_all();
      cmd(C_CREATE, 5, K_SOFT, 100);
      cmd(C_CREATE, 2, K_SOFT, 100);
      cmd(C_ACT, 5, K_NRT, 0);
      cmd(C_ACT, 2, K_NRT, 0);
      settle();
      chk("R7 tie lower id", int'(dispatch_id), 2);
   endtask

   task automatic t_edf();
      clear_all();
      cmd(C_CREATE, 1, K_HARD, 400);
      cmd(C_CREATE, 6, K_HARD, 100);
      cmd(C_ACT, 1, K_NRT, 0);
      cmd(C_ACT, 6, K_NRT, 0);
      settle();
      chk("R5 nearest deadline", int'(dispatch_id), 6);
      clear_all();
      cmd(C_CREATE, 2, K_HARD, 100);
      cmd(C_CREATE, 3, 2'd3, 50);
      cmd(C_ACT, 2, K_NRT, 0);
      repeat (80) @(negedge clk);
      cmd(C_ACT, 3, K_NRT, 0);
      settle();
      chk("R5 deadline not period", int'(dispatch_id), 2);
   endtask

   task automatic t_wrap();
      clear_all();
      cmd(C_CREATE, 0, K_HARD, 60000);
      cmd(C_CREATE, 4, K_HARD, 58000);
      cmd(C_ACT, 0, K_NRT, 0);
      repeat (10000) @(negedge clk);
      cmd(C_ACT, 4, K_NRT, 0);
      settle();
      chk("R6 wrapped deadline is later", int'(dispatch_id), 0);
      cmd(C_KILL, 0, K_NRT, 0);
      settle();
      chk("R6 remaining task", int'(dispatch_id), 4);
   endtask

   task automatic t_classes();
      clear_all();
      cmd(C_CREATE, 0, K_NRT, 0);
      cmd(C_CREATE, 7, K_SOFT, 1000);
      cmd(C_CREATE, 5, K_HARD, 60000);
      cmd(C_ACT, 0, K_NRT, 0);
      settle();
      chk("R2 nrt alone", int'(dispatch_id), 0);
      cmd(C_ACT, 7, K_NRT, 0);
      settle();
      chk("R2 soft over nrt", int'(dispatch_id), 7);
      chk("R10 preempt pulse", int'(preempt), 1);
      settle();
      chk("R10 pulse one cycle", int'(preempt), 0);
      cmd(C_ACT, 5, K_NRT, 0);
      settle();
      chk("R2 hard over soft", int'(dispatch_id), 5);
   endtask

   task automatic t_lifo();
      clear_all();
      cmd(C_CREATE, 0, K_SOFT, 300);
      cmd(C_CREATE, 1, K_SOFT, 200);
      cmd(C_CREATE, 2, K_HARD, 1000);
      cmd(C_ACT, 0, K_NRT, 0);
      cmd(C_ACT, 1, K_NRT, 0);
      cmd(C_ACT, 2, K_NRT, 0);
      settle();
      chk("R12 innermost running", int'(dispatch_id), 2);
      cmd(C_KILL, 2, K_NRT, 0);
      settle();
      chk("R12 resume last preempted", int'(dispatch_id), 1);
      chk("R10 no preempt on resume", int'(preempt), 0);
      cmd(C_KILL, 1, K_NRT, 0);
      settle();
      chk("R12 resume first preempted", int'(dispatch_id), 0);
   endtask

   task automatic t_sleep();
      clear_all();
      cmd(C_CREATE, 3, K_NRT, 0);
      cmd(C_ACT, 3, K_NRT, 0);
      settle();
      chk("R9 ready before sleep", int'(dispatch_valid), 1);
      cmd(C_SLEEP, 3, K_NRT, 40);
      settle();
      chk("R9 asleep", int'(dispatch_valid), 0);
      chk("R10 no preempt on sleep", int'(preempt), 0);
      repeat (30) @(negedge clk);
      chk("R9 still asleep", int'(dispatch_valid), 0);
      repeat (15) @(negedge clk);
      chk("R9 woken valid", int'(dispatch_valid), 1);
      chk("R9 woken id", int'(dispatch_id), 3);
   endtask

   task automatic t_same_cycle();
      clear_all();
      cmd(C_CREATE, 4, K_NRT, 0);
      cmd(C_CREATE, 6, K_NRT, 0);
      cmd(C_ACT, 4, K_NRT, 0);
      // sleep applied at edge E, wake applied at edge E+20
      cmd_valid = 1'b1; cmd_op = C_SLEEP; cmd_id = 3'd4; cmd_value = 16'd20;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (19) @(negedge clk);
      cmd(C_ACT, 6, K_NRT, 0);
      settle();
      chk("R13 tie on shared stamp", int'(dispatch_id), 4);
      cmd(C_KILL, 4, K_NRT, 0);
      settle();
      chk("R13 second arrival kept", int'(dispatch_valid), 1);
      chk("R13 second arrival id", int'(dispatch_id), 6);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      settle();
      t_reset();
      t_latency_ignore();
      t_fcfs();
      t_rm_tie();
      t_edf();
      t_wrap();
      t_classes();
      t_lifo();
      t_sleep();
      t_same_cycle();
      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
   end

endmodule